// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Upper Address Line Muxing

This block is one general-purpose I/O port of a microcontroller. It serves eight pins from six byte-wide registers on a simple peripheral bus: pin direction, output data, live pin-state readback, pull-up enable, open-drain enable and a shared function-control byte. The registers are written on the clock edge after a write strobe, and they are read back combinationally.

In the expanded bus modes the port also carries the upper external address lines. The five low pins always carry address lines 16 to 20. Each of the three high pins carries address line 21, 22 or 23 when its function-control enable bit and its direction bit are both set. In the single-chip modes every pin is plain I/O. During software standby the address pins either hold the last address they drove or release the pin, as set by an output-hold input. Hardware standby releases every pin and clears the direction register.

Top module: `gpio_addr_port`

## Requirements
- R1: After reset the data, pull-up and open-drain registers read 0x00, the function-control register reads 0xFF, and the direction register is cleared, so in single-chip mode no pin drives (`pin_oe_o` = 0).
- R2: A write strobe with `bus_addr_i` at 0xFF69 (data), 0xFE36 (pull-up), 0xFE3D (open-drain) or 0xFE33 (function control) updates that register on the next rising clock edge. A read of the same address returns the value written.
- R3: The direction register sits at 0xFE29 and is write-only. A read at that address returns 0xFF.
- R4: A read at 0xFF59 returns the present value of `pin_i`.
- R5: In single-chip modes (mode codes 0, 3, 4, 7), a pin whose direction bit is 1 drives its data bit (`pin_oe_o` = 1), and a pin whose direction bit is 0 is an input (`pin_oe_o` = 0).
- R6: For a general output pin whose open-drain bit is 1, a data bit of 0 drives low and a data bit of 1 turns the driver off.
- R7: In expanded modes (mode codes 1, 2, 5, 6), pins 0 to 4 drive `abus_hi_i[4:0]` (address lines 16 to 20) whatever their direction bits hold.
- R8: In expanded modes, pin n (n = 5, 6, 7) drives `abus_hi_i[n]` when function-control bit n and direction bit n are both 1. It is an input when function-control bit n is 1 and direction bit n is 0. It is general I/O as in R5 and R6 when function-control bit n is 0.
- R9: In software standby with `stby_hold_i` = 1, the address pins keep driving the address value present in the last cycle before standby was entered.
- R10: In software standby with `stby_hold_i` = 0, the address pins do not drive.
- R11: The direction register keeps its value through software standby. It is cleared while `hw_stby_i` is high.
- R12: While `hw_stby_i` is high, no pin drives and no pull-up is enabled.
- R13: `pin_pu_o[n]` is 1 only when pin n is an input, pull-up bit n is 1, and neither standby input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Register address, low 16 bits |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 when no read is active |
| mode_i | input | 3 | Operating mode code |
| hw_stby_i | input | 1 | Hardware standby |
| sw_stby_i | input | 1 | Software standby |
| stby_hold_i | input | 1 | Address pins keep driving in software standby |
| abus_hi_i | input | 8 | Internal address lines 23 to 16 (bit 0 = line 16) |
| pin_i | input | 8 | Sampled pin levels |
| pin_out_o | output | 8 | Per-pin output value |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
The pin function is swept over all eight mode codes, every combination of the three high function-control bits, four direction patterns (all clear, all set and two alternating ones), and both plain and open-drain outputs. The sweep separates forced address pins from enable-gated ones, gated inputs from gated address outputs, and single-chip codes from expanded codes. Standby is tried separately: hold on and hold off, a change of address during standby, and direction retention against hardware clearing. These runs separate a held value from a live one, and retention from clearing.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [15:0] ADR_DIR  = 16'hFE29;
  localparam logic [15:0] ADR_DATA = 16'hFF69;
  localparam logic [15:0] ADR_PIN  = 16'hFF59;
  localparam logic [15:0] ADR_PULL = 16'hFE36;
  localparam logic [15:0] ADR_ODRN = 16'hFE3D;
  localparam logic [15:0] ADR_FUNC = 16'hFE33;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIR, SEL_DATA, SEL_PIN, SEL_PULL, SEL_ODRN, SEL_FUNC
  } reg_sel_e;

  function automatic logic is_expanded(input logic [2:0] mode);
    return (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd5) || (mode == 3'd6);
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hw_stby_i,
  input  logic [15:0]     addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [PINS-1:0] wdata_i,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] rdata_o,
  output logic [PINS-1:0] dir_o,
  output logic [PINS-1:0] data_o,
  output logic [PINS-1:0] pull_o,
  output logic [PINS-1:0] odrn_o,
  output logic [PINS-1:0] func_o
);
  reg_sel_e sel;

  always_comb begin
    case (addr_i)
      ADR_DIR:  sel = SEL_DIR;
      ADR_DATA: sel = SEL_DATA;
      ADR_PIN:  sel = SEL_PIN;
      ADR_PULL: sel = SEL_PULL;
      ADR_ODRN: sel = SEL_ODRN;
      ADR_FUNC: sel = SEL_FUNC;
      default:  sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      data_o <= '0;
      pull_o <= '0;
      odrn_o <= '0;
      func_o <= '1;
    end else begin
      if (hw_stby_i)                    dir_o <= '0;
      else if (wr_i && sel == SEL_DIR)  dir_o <= wdata_i;
      if (wr_i && sel == SEL_DATA) data_o <= wdata_i;
      if (wr_i && sel == SEL_PULL) pull_o <= wdata_i;
      if (wr_i && sel == SEL_ODRN) odrn_o <= wdata_i;
      if (wr_i && sel == SEL_FUNC) func_o <= wdata_i;
    end
  end

  // direction register is write-only; reads return all ones
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        SEL_DIR:  rdata_o = '1;
        SEL_DATA: rdata_o = data_o;
        SEL_PIN:  rdata_o = pin_i;
        SEL_PULL: rdata_o = pull_o;
        SEL_ODRN: rdata_o = odrn_o;
        SEL_FUNC: rdata_o = func_o;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int PINS  = 8,
  parameter int FIXED = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            expanded_i,
  input  logic            sw_stby_i,
  input  logic            hw_stby_i,
  input  logic            hold_i,
  input  logic [PINS-1:0] abus_i,
  input  logic [PINS-1:0] dir_i,
  input  logic [PINS-1:0] data_i,
  input  logic [PINS-1:0] pull_i,
  input  logic [PINS-1:0] odrn_i,
  input  logic [PINS-1:0] func_i,
  output logic [PINS-1:0] out_o,
  output logic [PINS-1:0] oe_o,
  output logic [PINS-1:0] pu_o
);
  logic [PINS-1:0] abus_q;
  logic            addr_drive;

  // last address seen outside software standby
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         abus_q <= '0;
    else if (!sw_stby_i) abus_q <= abus_i;
  end

  assign addr_drive = !hw_stby_i && !(sw_stby_i && !hold_i);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    localparam bit Forced = (i < FIXED);
    logic is_addr;
    assign is_addr = expanded_i && (Forced || (func_i[i] && dir_i[i]));

    always_comb begin
      if (is_addr) begin
        out_o[i] = sw_stby_i ? abus_q[i] : abus_i[i];
        oe_o[i]  = addr_drive;
      end else if (dir_i[i]) begin
        out_o[i] = odrn_i[i] ? 1'b0 : data_i[i];
        oe_o[i]  = !hw_stby_i && !(odrn_i[i] && data_i[i]);
      end else begin
        out_o[i] = 1'b0;
        oe_o[i]  = 1'b0;
      end
      pu_o[i] = pull_i[i] && !is_addr && !dir_i[i] && !sw_stby_i && !hw_stby_i;
    end
  end
endmodule

// File: rtl/gpio_addr_port.sv
module gpio_addr_port
  import gpio_port_pkg::*;
#(
  parameter int PINS            = 8,
  parameter int FIXED_ADDR_PINS = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [15:0]     bus_addr_i,
  input  logic            bus_wr_i,
  input  logic            bus_rd_i,
  input  logic [PINS-1:0] bus_wdata_i,
  output logic [PINS-1:0] bus_rdata_o,
  input  logic [2:0]      mode_i,
  input  logic            hw_stby_i,
  input  logic            sw_stby_i,
  input  logic            stby_hold_i,
  input  logic [PINS-1:0] abus_hi_i,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] pin_out_o,
  output logic [PINS-1:0] pin_oe_o,
  output logic [PINS-1:0] pin_pu_o
);
  logic [PINS-1:0] dir, data, pull, odrn, func;
  logic            expanded;

  assign expanded = is_expanded(mode_i);

  gpio_port_regs #(.PINS(PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_stby_i(hw_stby_i),
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .wdata_i  (bus_wdata_i),
    .pin_i    (pin_i),
    .rdata_o  (bus_rdata_o),
    .dir_o    (dir),
    .data_o   (data),
    .pull_o   (pull),
    .odrn_o   (odrn),
    .func_o   (func)
  );

  gpio_pin_mux #(.PINS(PINS), .FIXED(FIXED_ADDR_PINS)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expanded_i(expanded),
    .sw_stby_i (sw_stby_i),
    .hw_stby_i (hw_stby_i),
    .hold_i    (stby_hold_i),
    .abus_i    (abus_hi_i),
    .dir_i     (dir),
    .data_i    (data),
    .pull_i    (pull),
    .odrn_i    (odrn),
    .func_i    (func),
    .out_o     (pin_out_o),
    .oe_o      (pin_oe_o),
    .pu_o      (pin_pu_o)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PINS  = 8,
  parameter int FIXED = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [15:0]     bus_addr_i,
  input logic            bus_rd_i,
  input logic [PINS-1:0] bus_rdata_o,
  input logic [2:0]      mode_i,
  input logic            hw_stby_i,
  input logic            sw_stby_i,
  input logic            stby_hold_i,
  input logic [PINS-1:0] abus_hi_i,
  input logic [PINS-1:0] pin_out_o,
  input logic [PINS-1:0] pin_oe_o,
  input logic [PINS-1:0] pin_pu_o
);
  a_r12_hw_stby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |-> (pin_oe_o == '0 && pin_pu_o == '0));

  a_r13_pu_only_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pu_o & pin_oe_o) == '0);

  a_r13_pu_off_sw_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_stby_i |-> pin_pu_o == '0);

  a_r3_dir_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == ADR_DIR) |-> bus_rdata_o == '1);

  a_r7_low_pins_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_expanded(mode_i) && !hw_stby_i && !sw_stby_i) |->
      (pin_oe_o[FIXED-1:0] == '1 && pin_out_o[FIXED-1:0] == abus_hi_i[FIXED-1:0]));

  a_r10_release_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_expanded(mode_i) && sw_stby_i && !stby_hold_i) |-> pin_oe_o[FIXED-1:0] == '0);

  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && $past(sw_stby_i) && stby_hold_i && is_expanded(mode_i)
     && $stable(mode_i)) |-> $stable(pin_out_o[FIXED-1:0]));
endmodule

bind gpio_addr_port gpio_port_chk #(.PINS(PINS), .FIXED(FIXED_ADDR_PINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_rd_i   (bus_rd_i),
  .bus_rdata_o(bus_rdata_o),
  .mode_i     (mode_i),
  .hw_stby_i  (hw_stby_i),
  .sw_stby_i  (sw_stby_i),
  .stby_hold_i(stby_hold_i),
  .abus_hi_i  (abus_hi_i),
  .pin_out_o  (pin_out_o),
  .pin_oe_o   (pin_oe_o),
  .pin_pu_o   (pin_pu_o)
);

// File: tb/test_gpio_addr_port.sv
module test_gpio_addr_port;
  localparam logic [15:0] A_DIR = 16'hFE29, A_DATA = 16'hFF69, A_PIN = 16'hFF59;
  localparam logic [15:0] A_PULL = 16'hFE36, A_ODRN = 16'hFE3D, A_FUNC = 16'hFE33;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic [2:0]  mode = '0;
  logic        hw = 1'b0, sw = 1'b0, hold = 1'b0;
  logic [7:0]  abus = '0, pins = '0;
  logic [7:0]  p_out, p_oe, p_pu;

  gpio_addr_port i_gpio_addr_port (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr_en), .bus_rd_i(rd_en),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mode_i(mode), .hw_stby_i(hw),
    .sw_stby_i(sw), .stby_hold_i(hold), .abus_hi_i(abus), .pin_i(pins),
    .pin_out_o(p_out), .pin_oe_o(p_oe), .pin_pu_o(p_pu)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  // expected pin function from the requirements (no standby)
  task automatic model(input logic [2:0] m, input logic [7:0] dir, dat, pul, odr, fn, ab,
                       output logic [7:0] eo, eoe, epu);
    logic ex;
    ex = (m == 1) || (m == 2) || (m == 5) || (m == 6);
    for (int i = 0; i < 8; i++) begin
      logic ia;
      ia = ex && (i < 5 || (fn[i] && dir[i]));
      if (ia) begin eo[i] = ab[i]; eoe[i] = 1'b1; end
      else if (dir[i]) begin
        eo[i] = odr[i] ? 1'b0 : dat[i];
        eoe[i] = !(odr[i] && dat[i]);
      end else begin eo[i] = 1'b0; eoe[i] = 1'b0; end
      epu[i] = pul[i] && !ia && !dir[i];
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, eo, eoe, epu, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_DATA, v); chk("R1 data reset", v, 8'h00);
    rd(A_PULL, v); chk("R1 pull reset", v, 8'h00);
    rd(A_ODRN, v); chk("R1 odrn reset", v, 8'h00);
    rd(A_FUNC, v); chk("R1 func reset", v, 8'hFF);
    #1 chk("R1 dir cleared oe", p_oe, 8'h00);

    // R2 write/readback, R3 dir read
    wr(A_DATA, 8'hA5); rd(A_DATA, v); chk("R2 data", v, 8'hA5);
    wr(A_PULL, 8'h3C); rd(A_PULL, v); chk("R2 pull", v, 8'h3C);
    wr(A_ODRN, 8'h81); rd(A_ODRN, v); chk("R2 odrn", v, 8'h81);
    wr(A_FUNC, 8'h42); rd(A_FUNC, v); chk("R2 func", v, 8'h42);
    wr(A_DIR, 8'h12);  rd(A_DIR, v);  chk("R3 dir read", v, 8'hFF);

    // R4 pin readback
    for (int k = 0; k < 256; k += 51) begin
      pins = 8'(k); rd(A_PIN, v); chk("R4 pin readback", v, 8'(k));
    end

    // R5 R6 R7 R8 R13 sweep
    for (int m = 0; m < 8; m++)
      for (int f = 0; f < 8; f++)
        for (int d = 0; d < 4; d++)
          for (int o = 0; o < 2; o++) begin
            logic [7:0] dp, op, fp;
            dp = (d == 0) ? 8'h00 : (d == 1) ? 8'hFF : (d == 2) ? 8'hA5 : 8'h5A;
            op = o ? 8'h3C : 8'h00;
            fp = {3'(f), 5'b0};
            mode = 3'(m);
            abus = 8'(m * 37 + f * 11 + d * 5 + o);
            wr(A_FUNC, fp); wr(A_DIR, dp); wr(A_DATA, 8'h96);
            wr(A_ODRN, op); wr(A_PULL, 8'h5F);
            @(negedge clk); #1;
            model(3'(m), dp, 8'h96, 8'h5F, op, fp, abus, eo, eoe, epu);
            chk("R5 R6 R7 R8 oe", p_oe, eoe);
            chk("R5 R6 R7 R8 out", p_out & p_oe, eo & eoe);
            chk("R13 pull-up", p_pu, epu);
          end

    // R9 hold in software standby
    mode = 3'd1; wr(A_FUNC, 8'hE0); wr(A_DIR, 8'hE0); wr(A_PULL, 8'h00); wr(A_ODRN, 8'h00);
    abus = 8'h6B; hold = 1'b1; held = 8'h6B;
    @(negedge clk); sw = 1'b1;
    @(negedge clk); abus = 8'h94;
    @(negedge clk); #1;
    chk("R9 held oe", p_oe, 8'hFF);
    chk("R9 held value", p_out, held);

    // R10 release without hold
    hold = 1'b0; #1;
    chk("R10 address pins off", p_oe, 8'h00);
    sw = 1'b0; #1;
    chk("R9 live after exit", p_out, 8'h94);

    // R11 retention in software standby, clearing in hardware standby
    mode = 3'd0; wr(A_DATA, 8'hC3); wr(A_DIR, 8'hFF); wr(A_PULL, 8'hFF);
    @(negedge clk); sw = 1'b1;
    @(negedge clk); #1 chk("R13 pull-up off sw stby", p_pu, 8'h00);
    chk("R11 dir kept in sw stby", p_oe, 8'hFF);
    sw = 1'b0;
    @(negedge clk); #1 chk("R11 dir kept after sw stby", p_oe, 8'hFF);
    wr(A_DIR, 8'h0F);
    @(negedge clk); #1 chk("R13 pull-up on inputs", p_pu, 8'hF0);
    hw = 1'b1; #1;
    chk("R12 no drive hw stby", p_oe, 8'h00);
    chk("R12 no pull-up hw stby", p_pu, 8'h00);
    @(negedge clk); hw = 1'b0; #1;
    chk("R11 dir cleared by hw stby", p_oe, 8'h00);
    mode = 3'd2; hw = 1'b1; #1;
    chk("R12 expanded no drive", p_oe, 8'h00);
    hw = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule